// File: doc/BRIEF.md
# Strobed Handshake Port Channel

This block is one 8-bit peripheral port channel that moves data under a strobe-and-acknowledge handshake, with flags and an interrupt request for the CPU. A static direction input selects the mode. In receive mode, an external device drives the pins and pulls its strobe low. The pin value is latched, a buffer-full flag rises, and once the strobe returns high the channel can raise an interrupt. The CPU read cycle then clears the interrupt and the flag. In transmit mode, a CPU write loads the output latch and asserts an active-low buffer-full flag. The external device's acknowledge clears that flag, and the end of the acknowledge can raise an interrupt. The next CPU write clears it.

An interrupt-enable flop is written only by single-bit set/reset commands aimed at the bit position of the channel's strobe or acknowledge pin. The channel also returns its status bits (interrupt, enable and buffer flag) at their bit positions within the port C read word, together with a mask of the positions it owns. The parameter `GROUP_B` picks the pin layout: the upper channel or the lower channel. The external strobe or acknowledge passes through a synchroniser and an edge detector. The CPU read and write strobes arrive already synchronous to the clock.

The buffer flag comes from a four-state machine. The states are HS_IN_EMPTY, HS_IN_FULL, HS_OUT_EMPTY and HS_OUT_FULL. The transitions are:
- **fill_in**: HS_IN_EMPTY to HS_IN_FULL on a strobe falling edge.
- **drain_in**: HS_IN_FULL to HS_IN_EMPTY on a read rising edge with no strobe falling edge.
- **fill_out**: HS_OUT_EMPTY to HS_OUT_FULL on a write rising edge.
- **drain_out**: HS_OUT_FULL to HS_OUT_EMPTY on an acknowledge falling edge with no write rising edge.
- **to_out**: any receive state to HS_OUT_EMPTY when the direction input selects transmit.
- **to_in**: any transmit state to HS_IN_EMPTY when the direction input selects receive.

Top module: `strobe_port_channel`

## Requirements
- R1: After reset, ibf is 0, obf_n is 1, intr is 0, the enable flop is 0, and both data latches hold 0.
- R2: In receive mode, while the synchronised strobe is low the pin value is copied into the input latch. cpu_rdata shows that latch. Pin changes while the strobe is high leave cpu_rdata unchanged.
- R3: ibf rises on the strobe falling edge. It falls on the rising edge of cpu_rd_n, not on its falling edge.
- R4: In receive mode, intr rises on the strobe rising edge while ibf is 1 and the enable flop is 1. It falls on the falling edge of cpu_rd_n.
- R5: In transmit mode, the rising edge of cpu_wr_n loads cpu_wdata into port_out and drives obf_n low. The falling edge of cpu_wr_n does neither. port_oe is 1 in transmit mode and 0 in receive mode.
- R6: In transmit mode, obf_n returns high on the acknowledge falling edge.
- R7: In transmit mode, intr rises on the acknowledge rising edge while obf_n is 1 and the enable flop is 1. It falls on the falling edge of cpu_wr_n.
- R8: A set/reset command (bsr_valid with bsr_bit and bsr_val) writes the enable flop only when bsr_bit equals the channel's own pin position. That position is 4 for the upper channel in receive mode, 6 for the upper channel in transmit mode, and 2 for the lower channel. Commands to any other position are ignored.
- R9: intr stays low while the enable flop is 0. Clearing the enable flop drops a pending intr.
- R10: pc_status puts each bit at a fixed position, and every bit outside pc_status_mask reads 0.
  - Upper channel, receive: intr at bit 3, enable at bit 4, ibf at bit 5 (mask 0x38).
  - Upper channel, transmit: intr at bit 3, enable at bit 6, obf_n at bit 7 (mask 0xC8).
  - Lower channel: intr at bit 0, ibf or obf_n at bit 1, enable at bit 2 (mask 0x07).
- R11: A change of cfg_dir_in empties the buffer state (ibf 0, obf_n 1) and clears intr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | 1 selects receive mode, 0 selects transmit mode |
| cpu_rd_n | input | 1 | Synchronous active-low CPU read strobe for this channel |
| cpu_wr_n | input | 1 | Synchronous active-low CPU write strobe for this channel |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Input latch contents |
| bsr_valid | input | 1 | Port C single-bit set/reset command valid |
| bsr_bit | input | 3 | Port C bit addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| ext_strobe_n | input | 1 | Asynchronous strobe (receive) or acknowledge (transmit), active low |
| port_in | input | DATA_W | Port pins as inputs |
| port_out | output | DATA_W | Output latch driven to the pins |
| port_oe | output | 1 | Pin output enable |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |
| pc_status | output | 8 | Status bits at their port C read positions |
| pc_status_mask | output | 8 | Port C positions owned by this channel |

## Verification
On every cycle the assertions check the following:
- Each flag change happens only in the direction that allows it.
- The flags are empty in the opposite direction.
- An interrupt rises only when the matching buffer condition holds, and never while the enable flop is clear.
- The input latch holds while the strobe is high.

The edge choices need the directed scenarios:
- The flag and the interrupt react to opposite edges of the same strobe.
- Read and write strobes act on their falling edge for the interrupt and on their rising edge for the flags.
- Set/reset commands hit or miss the enable flop depending on the bit position.
- The status word layout differs between the two channel variants.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int PC_W     = 8;
    localparam int PC_IDX_W = $clog2(PC_W);

    typedef enum logic [1:0] {
        HS_IN_EMPTY  = 2'd0,
        HS_IN_FULL   = 2'd1,
        HS_OUT_EMPTY = 2'd2,
        HS_OUT_FULL  = 2'd3
    } hs_state_e;

endpackage

// File: rtl/spc_edge_sync.sv
// Multi-stage synchroniser for an asynchronous active-low line, with edge detection.
module spc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_n};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign fall  = prev_q & ~level;
    assign rise  = ~prev_q & level;
endmodule

// File: rtl/spc_cpu_edge.sv
// Edge detection for already-synchronous active-low CPU strobes.
module spc_cpu_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= lvl_n[i];
        end

        assign fall[i] = prev_q & ~lvl_n[i];
        assign rise[i] = ~prev_q & lvl_n[i];
    end
endmodule

// File: rtl/spc_handshake_fsm.sv
// Buffer-flag state machine shared by receive and transmit modes.
module spc_handshake_fsm
    import spc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    input  logic ext_fall,
    input  logic rd_rise,
    input  logic wr_rise,
    output logic ibf,
    output logic obf_n
);
    hs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IN_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IN_EMPTY: begin
                if (!dir_in)       state_d = HS_OUT_EMPTY;   // to_out
                else if (ext_fall) state_d = HS_IN_FULL;     // fill_in
            end
            HS_IN_FULL: begin
                if (!dir_in)                   state_d = HS_OUT_EMPTY; // to_out
                else if (rd_rise && !ext_fall) state_d = HS_IN_EMPTY;  // drain_in
            end
            HS_OUT_EMPTY: begin
                if (dir_in)       state_d = HS_IN_EMPTY;     // to_in
                else if (wr_rise) state_d = HS_OUT_FULL;     // fill_out
            end
            HS_OUT_FULL: begin
                if (dir_in)                    state_d = HS_IN_EMPTY;  // to_in
                else if (ext_fall && !wr_rise) state_d = HS_OUT_EMPTY; // drain_out
            end
            default: state_d = HS_IN_EMPTY;
        endcase
    end

    always_comb begin
        ibf   = 1'b0;
        obf_n = 1'b1;
        unique case (state_q)
            HS_IN_EMPTY:  begin ibf = 1'b0; obf_n = 1'b1; end
            HS_IN_FULL:   begin ibf = 1'b1; obf_n = 1'b1; end
            HS_OUT_EMPTY: begin ibf = 1'b0; obf_n = 1'b1; end
            HS_OUT_FULL:  begin ibf = 1'b0; obf_n = 1'b0; end
            default:      begin ibf = 1'b0; obf_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/spc_intr_ctl.sv
// Interrupt-enable flop, interrupt request and port C status placement.
module spc_intr_ctl
    import spc_pkg::*;
#(
    parameter bit GROUP_B = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_in,
    input  logic                ibf,
    input  logic                obf_n,
    input  logic                ext_rise,
    input  logic                rd_fall,
    input  logic                wr_fall,
    input  logic                bsr_valid,
    input  logic [PC_IDX_W-1:0] bsr_bit,
    input  logic                bsr_val,
    output logic                intr,
    output logic                inte,
    output logic [PC_W-1:0]     pc_status,
    output logic [PC_W-1:0]     pc_status_mask
);
    localparam logic [PC_IDX_W-1:0] INTR_POS   = GROUP_B ? PC_IDX_W'(0) : PC_IDX_W'(3);
    localparam logic [PC_IDX_W-1:0] B_FLAG_POS = PC_IDX_W'(1);
    localparam logic [PC_IDX_W-1:0] B_INTE_POS = PC_IDX_W'(2);
    localparam logic [PC_IDX_W-1:0] A_IN_INTE  = PC_IDX_W'(4);
    localparam logic [PC_IDX_W-1:0] A_IN_FLAG  = PC_IDX_W'(5);
    localparam logic [PC_IDX_W-1:0] A_OUT_INTE = PC_IDX_W'(6);
    localparam logic [PC_IDX_W-1:0] A_OUT_FLAG = PC_IDX_W'(7);

    logic [PC_IDX_W-1:0] inte_pos, flag_pos;
    logic                inte_q, intr_q, dir_q;
    logic                dir_chg, set_req, clr_req;

    always_comb begin
        if (GROUP_B) begin
            inte_pos = B_INTE_POS;
            flag_pos = B_FLAG_POS;
        end else if (dir_in) begin
            inte_pos = A_IN_INTE;
            flag_pos = A_IN_FLAG;
        end else begin
            inte_pos = A_OUT_INTE;
            flag_pos = A_OUT_FLAG;
        end
    end

    assign dir_chg = dir_q != dir_in;
    assign set_req = inte_q & ext_rise & (dir_in ? ibf : obf_n);
    assign clr_req = dir_in ? rd_fall : wr_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inte_q <= 1'b0;
            intr_q <= 1'b0;
            dir_q  <= 1'b1;
        end else begin
            dir_q <= dir_in;
            if (bsr_valid && (bsr_bit == inte_pos))
                inte_q <= bsr_val;
            if (!inte_q || dir_chg) intr_q <= 1'b0;
            else if (set_req)       intr_q <= 1'b1;
            else if (clr_req)       intr_q <= 1'b0;
        end
    end

    always_comb begin
        pc_status                = '0;
        pc_status_mask           = '0;
        pc_status[INTR_POS]      = intr_q;
        pc_status[inte_pos]      = inte_q;
        pc_status[flag_pos]      = dir_in ? ibf : obf_n;
        pc_status_mask[INTR_POS] = 1'b1;
        pc_status_mask[inte_pos] = 1'b1;
        pc_status_mask[flag_pos] = 1'b1;
    end

    assign intr = intr_q;
    assign inte = inte_q;
endmodule

// File: rtl/strobe_port_channel.sv
module strobe_port_channel
    import spc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit GROUP_B     = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_dir_in,
    input  logic                cpu_rd_n,
    input  logic                cpu_wr_n,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                bsr_valid,
    input  logic [PC_IDX_W-1:0] bsr_bit,
    input  logic                bsr_val,
    input  logic                ext_strobe_n,
    input  logic [DATA_W-1:0]   port_in,
    output logic [DATA_W-1:0]   port_out,
    output logic                port_oe,
    output logic                ibf,
    output logic                obf_n,
    output logic                intr,
    output logic [PC_W-1:0]     pc_status,
    output logic [PC_W-1:0]     pc_status_mask
);
    localparam int RD_IDX = 0;
    localparam int WR_IDX = 1;

    logic              stb_lvl, ext_fall, ext_rise;
    logic [1:0]        cpu_fall, cpu_rise;
    logic              inte_w;
    logic [DATA_W-1:0] pin_pipe [SYNC_STAGES];
    logic [DATA_W-1:0] in_latch_q, out_latch_q;

    spc_edge_sync #(.STAGES(SYNC_STAGES)) ext_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (ext_strobe_n),
        .level   (stb_lvl),
        .fall    (ext_fall),
        .rise    (ext_rise)
    );

    spc_cpu_edge #(.N(2)) cpu_edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n ({cpu_wr_n, cpu_rd_n}),
        .fall  (cpu_fall),
        .rise  (cpu_rise)
    );

    spc_handshake_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_in   (cfg_dir_in),
        .ext_fall (ext_fall),
        .rd_rise  (cpu_rise[RD_IDX]),
        .wr_rise  (cpu_rise[WR_IDX]),
        .ibf      (ibf),
        .obf_n    (obf_n)
    );

    spc_intr_ctl #(.GROUP_B(GROUP_B)) intr_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .dir_in         (cfg_dir_in),
        .ibf            (ibf),
        .obf_n          (obf_n),
        .ext_rise       (ext_rise),
        .rd_fall        (cpu_fall[RD_IDX]),
        .wr_fall        (cpu_fall[WR_IDX]),
        .bsr_valid      (bsr_valid),
        .bsr_bit        (bsr_bit),
        .bsr_val        (bsr_val),
        .intr           (intr),
        .inte           (inte_w),
        .pc_status      (pc_status),
        .pc_status_mask (pc_status_mask)
    );

    // Pin data travels through the same depth as the strobe so both stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pin_pipe[i] <= '0;
        end else begin
            pin_pipe[0] <= port_in;
            for (int i = 1; i < SYNC_STAGES; i++) pin_pipe[i] <= pin_pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_latch_q  <= '0;
            out_latch_q <= '0;
        end else begin
            if (cfg_dir_in && !stb_lvl)
                in_latch_q <= pin_pipe[SYNC_STAGES-1];
            if (!cfg_dir_in && cpu_rise[WR_IDX])
                out_latch_q <= cpu_wdata;
        end
    end

    assign cpu_rdata = in_latch_q;
    assign port_out  = out_latch_q;
    assign port_oe   = ~cfg_dir_in;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_dir_in,
    input logic              stb_lvl,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              ibf,
    input logic              obf_n,
    input logic              intr,
    input logic              inte_w
);
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb_lvl) || !$past(cfg_dir_in)) |-> $stable(cpu_rdata)); // R2

    AST_IBF_RISE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(cfg_dir_in)); // R3

    AST_RX_INTR_NEEDS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(intr) && $past(cfg_dir_in)) |-> $past(ibf)); // R4

    AST_OBF_FALL_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf_n) |-> !$past(cfg_dir_in)); // R5

    AST_TX_INTR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(intr) && !$past(cfg_dir_in)) |-> $past(obf_n)); // R7

    AST_INTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!inte_w && !$past(inte_w)) |-> !intr); // R9

    AST_TX_NO_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_dir_in) |-> !ibf); // R11

    AST_RX_NO_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_dir_in) |-> obf_n); // R11
endmodule

bind strobe_port_channel spc_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_dir_in (cfg_dir_in),
    .stb_lvl    (stb_lvl),
    .cpu_rdata  (cpu_rdata),
    .ibf        (ibf),
    .obf_n      (obf_n),
    .intr       (intr),
    .inte_w     (inte_w)
);

// File: tb/strobe_port_channel_tb_top.sv
module strobe_port_channel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dir_in = 1'b1;
    logic       cpu_rd_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic [7:0] cpu_wdata = '0;
    logic       bsr_valid = 1'b0;
    logic [2:0] bsr_bit = '0;
    logic       bsr_val = 1'b0;
    logic       ext_strobe_n = 1'b1;
    logic [7:0] port_in = '0;

    logic [7:0] cpu_rdata, port_out, pc_status, pc_status_mask;
    logic       port_oe, ibf, obf_n, intr;
    logic [7:0] b_rdata, b_out, b_status, b_mask;
    logic       b_oe, b_ibf, b_obf_n, b_intr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    strobe_port_channel #(.GROUP_B(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .bsr_valid(bsr_valid), .bsr_bit(bsr_bit),
        .bsr_val(bsr_val), .ext_strobe_n(ext_strobe_n), .port_in(port_in),
        .port_out(port_out), .port_oe(port_oe), .ibf(ibf), .obf_n(obf_n),
        .intr(intr), .pc_status(pc_status), .pc_status_mask(pc_status_mask)
    );

    strobe_port_channel #(.GROUP_B(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_wdata(cpu_wdata),
        .cpu_rdata(b_rdata), .bsr_valid(bsr_valid), .bsr_bit(bsr_bit),
        .bsr_val(bsr_val), .ext_strobe_n(ext_strobe_n), .port_in(port_in),
        .port_out(b_out), .port_oe(b_oe), .ibf(b_ibf), .obf_n(b_obf_n),
        .intr(b_intr), .pc_status(b_status), .pc_status_mask(b_mask)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bsr(input logic [2:0] b, input logic v);
        bsr_valid = 1'b1; bsr_bit = b; bsr_val = v;
        step(1);
        bsr_valid = 1'b0;
        step(1);
    endtask

    task automatic strobe_low();  ext_strobe_n = 1'b0; step(5); endtask
    task automatic strobe_high(); ext_strobe_n = 1'b1; step(5); endtask

    task automatic t_reset();
        chk("R1 ibf", ibf, 0);
        chk("R1 obf_n", obf_n, 1);
        chk("R1 intr", intr, 0);
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 port_out", port_out, 8'h00);
        chk("R10 R1 status rx", pc_status, 8'h00);
        chk("R10 mask rx", pc_status_mask, 8'h38);
        chk("R10 mask grp b", b_mask, 8'h07);
    endtask

    task automatic t_inte_select();
        bsr(3'd6, 1'b1);
        chk("R8 wrong bit ignored", pc_status[4], 0);
        bsr(3'd4, 1'b1);
        chk("R8 rx enable bit 4", pc_status[4], 1);
        chk("R8 grp b unaffected", b_status[2], 0);
    endtask

    task automatic t_rx_cycle();
        port_in = 8'hA5;
        strobe_low();
        chk("R3 ibf on strobe fall", ibf, 1);
        chk("R4 no intr while strobe low", intr, 0);
        strobe_high();
        chk("R4 intr on strobe rise", intr, 1);
        chk("R2 latched data", cpu_rdata, 8'hA5);
        chk("R10 status rx full", pc_status, 8'h38);
        port_in = 8'h5A;
        step(4);
        chk("R2 pins ignored while strobe high", cpu_rdata, 8'hA5);
        cpu_rd_n = 1'b0; step(3);
        chk("R4 intr cleared by read fall", intr, 0);
        chk("R3 ibf held during read", ibf, 1);
        cpu_rd_n = 1'b1; step(3);
        chk("R3 ibf cleared by read rise", ibf, 0);
    endtask

    task automatic t_intr_gate();
        bsr(3'd4, 1'b0);
        port_in = 8'h11;
        strobe_low(); strobe_high();
        chk("R9 ibf without enable", ibf, 1);
        chk("R9 no intr without enable", intr, 0);
        chk("R10 status ibf only", pc_status, 8'h20);
        cpu_rd_n = 1'b0; step(2); cpu_rd_n = 1'b1; step(3);
        bsr(3'd4, 1'b1);
        strobe_low(); strobe_high();
        chk("R4 intr with enable", intr, 1);
        bsr(3'd4, 1'b0);
        step(2);
        chk("R9 clearing enable drops intr", intr, 0);
        cpu_rd_n = 1'b0; step(2); cpu_rd_n = 1'b1; step(3);
    endtask

    task automatic t_grp_b_rx();
        bsr(3'd2, 1'b1);
        chk("R8 grp b enable bit 2", b_status[2], 1);
        strobe_low(); strobe_high();
        chk("R10 grp b status full", b_status, 8'h07);
        cpu_rd_n = 1'b0; step(2); cpu_rd_n = 1'b1; step(3);
        chk("R10 grp b status after read", b_status, 8'h04);
    endtask

    task automatic t_tx_cycle();
        cfg_dir_in = 1'b0; step(3);
        chk("R5 oe in tx", port_oe, 1);
        chk("R10 mask tx", pc_status_mask, 8'hC8);
        bsr(3'd6, 1'b1);
        chk("R8 tx enable bit 6", pc_status[6], 1);
        bsr(3'd4, 1'b0);
        chk("R8 bit 4 ignored in tx", pc_status[6], 1);
        cpu_wdata = 8'h96;
        cpu_wr_n = 1'b0; step(3);
        chk("R5 obf not on write fall", obf_n, 1);
        cpu_wr_n = 1'b1; step(3);
        chk("R5 obf on write rise", obf_n, 0);
        chk("R5 port data", port_out, 8'h96);
        strobe_low();
        chk("R6 obf cleared by ack fall", obf_n, 1);
        chk("R7 no intr during ack", intr, 0);
        strobe_high();
        chk("R7 intr on ack rise", intr, 1);
        chk("R10 status tx", pc_status, 8'hC8);
        cpu_wdata = 8'h3C;
        cpu_wr_n = 1'b0; step(3);
        chk("R7 intr cleared by write fall", intr, 0);
        cpu_wr_n = 1'b1; step(3);
        chk("R5 second write data", port_out, 8'h3C);
    endtask

    task automatic t_dir_change();
        cfg_dir_in = 1'b1; step(3);
        chk("R11 obf empties on switch", obf_n, 1);
        chk("R5 oe off in rx", port_oe, 0);
        cfg_dir_in = 1'b0; step(3);
        strobe_low(); strobe_high();
        chk("R7 intr before switch", intr, 1);
        cfg_dir_in = 1'b1; step(3);
        chk("R11 intr cleared on switch", intr, 0);
        chk("R11 ibf empty on switch", ibf, 0);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_inte_select();
        t_rx_cycle();
        t_intr_gate();
        t_grp_b_rx();
        t_tx_cycle();
        t_dir_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule